// File: doc/BRIEF.md
# Go-Back-N Retransmission Sender Control

This block is the transmit-side sequencing engine of a link that recovers from loss by resending. It numbers outgoing frames with a wrapping 3-bit counter and offers each number to a frame source through a request/grant handshake. It keeps at most four granted frames awaiting acknowledgement. A payload store outside the block supplies the frame that matches the number offered. When a frame goes missing, the engine moves its send pointer back to the oldest unconfirmed frame and offers every later frame again, in order.

Confirmations arrive as cumulative reports. A positive report for number n confirms n and everything before it. A negative report for n also confirms everything up to n, and it states that something after n was lost. A single timer watches the oldest unconfirmed frame and forces the same rewind when the far end stays silent too long. An ack that lands in the same cycle as a timer expiry is processed first. The expiry is only acted on if that ack was not accepted.

Top module: `gbn_sender_ctrl`

## Requirements
- R1: After reset, new frames are numbered 0, 1, 2, ... modulo 8. `tx_seq` shows the number on offer, and a cycle with both `tx_req` and `tx_gnt` high consumes it, so `tx_seq` moves to the following number.
- R2: `in_flight` counts the frames granted at least once that are not yet confirmed. It never exceeds 4, and `win_full` is high exactly when it equals 4.
- R3: A positive report (`ack_neg`=0) is accepted when its number n lies in the unconfirmed range base .. base+in_flight-1 (modulo 8). Acceptance sets `win_base` to n+1 and reduces `in_flight` to match.
- R4: A report whose number is outside the unconfirmed range is ignored. `win_base`, `in_flight` and `tx_seq` are unchanged by it.
- R5: When no resend is pending (`tx_retx`=0), `tx_req` is high only if `data_avail` is high and `in_flight` is below 4. While a resend is pending, `tx_req` is high whatever `data_avail` is.
- R6: An accepted negative report (`ack_neg`=1) for n sets both `win_base` and `tx_seq` to n+1. It pulses `rewind` in that cycle, and the frames from n+1 up to the highest number already sent are then offered again with `tx_retx`=1.
- R7: The timer advances on every clock edge that finds frames outstanding. Once it has advanced TMO_CYCLES-1 times since its last restart, `rewind` is high in that cycle and `tx_seq` returns to `win_base` at the next edge.
- R8: The timer restarts from zero whenever the base advances or a rewind occurs. It is held at zero while nothing is outstanding.
- R9: If a report is accepted in the same cycle the timer expires, the report is applied and the expiry is dropped, unless the report is negative. If the report is ignored, the expiry still causes a rewind.
- R10: Out of reset, `win_base`, `tx_seq` and `in_flight` are 0, and `tx_req` is low while `data_avail` is low.
- R11: If an accepted positive report moves the base past a send pointer that had been rewound, `tx_seq` jumps forward to the new base.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| data_avail | input | 1 | A new frame is ready to be numbered |
| tx_req | output | 1 | A frame with number `tx_seq` should be sent |
| tx_seq | output | SEQ_W | Number of the frame on offer |
| tx_retx | output | 1 | The offered frame is a resend |
| tx_gnt | input | 1 | The frame on offer is taken this cycle |
| ack_valid | input | 1 | An acknowledgement report is present |
| ack_neg | input | 1 | 0 = positive report, 1 = negative report |
| ack_num | input | SEQ_W | Highest frame number confirmed by the report |
| win_base | output | SEQ_W | Oldest unconfirmed frame number |
| in_flight | output | SEQ_W | Number of frames sent and unconfirmed |
| win_full | output | 1 | Four frames are unconfirmed |
| rewind | output | 1 | The send pointer returns to the base at the next edge |

## Verification
A base pointer that is out by one shows up in the cycle after the report as a wrong `win_base` and `in_flight`. From then on it also changes which later reports are accepted. A send pointer that misses a rewind shows at the next edge as a `tx_seq` that differs from `win_base` with `tx_retx` low. A timer that is out by a single count moves the `rewind` pulse by exactly one cycle. For that reason the bench compares every output on every clock against a behavioural model, and it runs timed scenarios that pin the expiry to a specific cycle.

// File: rtl/gbn_pkg.sv
package gbn_pkg;

  typedef enum logic {
    ACK_POS = 1'b0,
    ACK_NEG = 1'b1
  } ack_kind_e;

  typedef struct packed {
    logic take;  // report number lies in the unconfirmed range
    logic neg;   // accepted report is negative
  } ack_verdict_t;

endpackage

// File: rtl/gbn_ack_check.sv
module gbn_ack_check #(
  parameter int SEQ_W = 3
) (
  input  logic                  ack_valid,
  input  gbn_pkg::ack_kind_e    ack_kind,
  input  logic [SEQ_W-1:0]      ack_num,
  input  logic [SEQ_W-1:0]      base_q,
  input  logic [SEQ_W-1:0]      top_q,
  output gbn_pkg::ack_verdict_t verdict,
  output logic [SEQ_W-1:0]      base_next,
  output logic [SEQ_W-1:0]      outstanding
);
  import gbn_pkg::*;

  // distance from b forward to a on the sequence ring
  function automatic logic [SEQ_W-1:0] ring_dist(input logic [SEQ_W-1:0] a,
                                                 input logic [SEQ_W-1:0] b);
    return a - b;
  endfunction

  logic in_range;

  assign outstanding  = ring_dist(top_q, base_q);
  assign in_range     = ring_dist(ack_num, base_q) < outstanding;
  assign verdict.take = ack_valid && in_range;
  assign verdict.neg  = ack_valid && in_range && (ack_kind == ACK_NEG);
  assign base_next    = verdict.take ? (ack_num + SEQ_W'(1)) : base_q;

endmodule

// File: rtl/gbn_loss_timer.sv
module gbn_loss_timer #(
  parameter int LIMIT = 64,
  localparam int CW   = (LIMIT > 2) ? $clog2(LIMIT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic running,
  input  logic restart,
  output logic expire
);

  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign expire = running && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (restart || !running) cnt_q <= '0;
    else                         cnt_q <= cnt_q + CW'(1);
  end

  AST_TMR_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> cnt_q == '0); // R8
  AST_TMR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt_q == '0); // R8
  AST_TMR_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R7

endmodule

// File: rtl/gbn_window.sv
module gbn_window #(
  parameter int SEQ_W = 3,
  parameter int WIN   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_avail,
  input  logic             tx_gnt,
  input  logic             ack_take,
  input  logic [SEQ_W-1:0] base_next,
  input  logic             rewind,
  output logic [SEQ_W-1:0] base_q,
  output logic [SEQ_W-1:0] next_q,
  output logic [SEQ_W-1:0] top_q,
  output logic             tx_req,
  output logic             tx_retx
);

  localparam logic [SEQ_W-1:0] WIN_V = SEQ_W'(WIN);

  function automatic logic [SEQ_W-1:0] ring_dist(input logic [SEQ_W-1:0] a,
                                                 input logic [SEQ_W-1:0] b);
    return a - b;
  endfunction

  function automatic logic [SEQ_W-1:0] seq_inc(input logic [SEQ_W-1:0] a);
    return a + SEQ_W'(1);
  endfunction

  logic [SEQ_W-1:0] used;
  logic             room;
  logic             sent;
  logic [SEQ_W-1:0] next_sent;
  logic             passed_by_ack;
  logic [SEQ_W-1:0] next_d;
  logic [SEQ_W-1:0] top_d;

  assign used      = ring_dist(top_q, base_q);
  assign room      = used < WIN_V;
  assign tx_retx   = (next_q != top_q);
  assign tx_req    = tx_retx || (data_avail && room);
  assign sent      = tx_req && tx_gnt;
  assign next_sent = sent ? seq_inc(next_q) : next_q;
  assign top_d     = (sent && !tx_retx) ? seq_inc(top_q) : top_q;

  // the base moved beyond a pointer that was sent back for resending
  assign passed_by_ack = ack_take &&
                         (ring_dist(next_sent, base_q) < ring_dist(base_next, base_q));

  always_comb begin
    next_d = next_sent;
    if (rewind || passed_by_ack) next_d = base_next;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      next_q <= '0;
      top_q  <= '0;
    end else begin
      base_q <= base_next;
      next_q <= next_d;
      top_q  <= top_d;
    end
  end

  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ring_dist(top_q, base_q) <= WIN_V); // R2
  AST_FULL_NO_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_retx && ring_dist(top_q, base_q) == WIN_V) |-> !tx_req); // R5
  AST_BASE_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_take |=> base_q == $past(base_q)); // R4
  AST_REWIND_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    rewind |=> next_q == base_q); // R6
  AST_NEXT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ring_dist(next_q, base_q) <= ring_dist(top_q, base_q)); // R1

endmodule

// File: rtl/gbn_sender_ctrl.sv
module gbn_sender_ctrl #(
  parameter int SEQ_W      = 3,
  parameter int WIN        = 4,
  parameter int TMO_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_avail,
  output logic             tx_req,
  output logic [SEQ_W-1:0] tx_seq,
  output logic             tx_retx,
  input  logic             tx_gnt,
  input  logic             ack_valid,
  input  logic             ack_neg,
  input  logic [SEQ_W-1:0] ack_num,
  output logic [SEQ_W-1:0] win_base,
  output logic [SEQ_W-1:0] in_flight,
  output logic             win_full,
  output logic             rewind
);
  import gbn_pkg::*;

  ack_kind_e        ack_kind;
  ack_verdict_t     verdict;
  logic [SEQ_W-1:0] base_q;
  logic [SEQ_W-1:0] next_q;
  logic [SEQ_W-1:0] top_q;
  logic [SEQ_W-1:0] base_next;
  logic [SEQ_W-1:0] outstanding;
  logic             tmr_expire;
  logic             tmr_restart;
  logic             tmr_running;
  logic             nak_loss;
  logic             tmo_loss;

  assign ack_kind = ack_neg ? ACK_NEG : ACK_POS;

  gbn_ack_check #(.SEQ_W(SEQ_W)) u_ack (
    .ack_valid  (ack_valid),
    .ack_kind   (ack_kind),
    .ack_num    (ack_num),
    .base_q     (base_q),
    .top_q      (top_q),
    .verdict    (verdict),
    .base_next  (base_next),
    .outstanding(outstanding)
  );

  // an accepted report wins over an expiry in the same cycle
  assign nak_loss    = verdict.neg;
  assign tmo_loss    = tmr_expire && !verdict.take;
  assign rewind      = nak_loss || tmo_loss;
  assign tmr_restart = verdict.take || rewind;
  assign tmr_running = (outstanding != '0);

  gbn_loss_timer #(.LIMIT(TMO_CYCLES)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .running(tmr_running),
    .restart(tmr_restart),
    .expire (tmr_expire)
  );

  gbn_window #(.SEQ_W(SEQ_W), .WIN(WIN)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_avail(data_avail),
    .tx_gnt    (tx_gnt),
    .ack_take  (verdict.take),
    .base_next (base_next),
    .rewind    (rewind),
    .base_q    (base_q),
    .next_q    (next_q),
    .top_q     (top_q),
    .tx_req    (tx_req),
    .tx_retx   (tx_retx)
  );

  assign tx_seq    = next_q;
  assign win_base  = base_q;
  assign in_flight = outstanding;
  assign win_full  = (outstanding == SEQ_W'(WIN));

  AST_ACK_BEATS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_expire && verdict.take && !ack_neg) |-> !rewind); // R9
  AST_EXPIRY_ACTS: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_expire && !ack_valid) |=> tx_seq == win_base); // R7
  AST_POS_ACK_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict.take && !ack_neg) |=> win_base == $past(ack_num) + SEQ_W'(1)); // R3

endmodule

// File: tb/sim_gbn_sender_ctrl.sv
module sim_gbn_sender_ctrl;

  localparam int TMO = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       data_avail = 1'b0;
  logic       tx_gnt = 1'b0;
  logic       ack_valid = 1'b0;
  logic       ack_neg = 1'b0;
  logic [2:0] ack_num = 3'd0;
  logic       tx_req;
  logic [2:0] tx_seq;
  logic       tx_retx;
  logic [2:0] win_base;
  logic [2:0] in_flight;
  logic       win_full;
  logic       rewind;

  int nchk = 0;
  int nfail = 0;
  int mb = 0, mn = 0, mt = 0, mc = 0;  // model base, send pointer, top, timer
  logic seen_rew;
  logic done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  gbn_sender_ctrl #(.SEQ_W(3), .WIN(4), .TMO_CYCLES(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .data_avail(data_avail),
    .tx_req(tx_req), .tx_seq(tx_seq), .tx_retx(tx_retx), .tx_gnt(tx_gnt),
    .ack_valid(ack_valid), .ack_neg(ack_neg), .ack_num(ack_num),
    .win_base(win_base), .in_flight(in_flight), .win_full(win_full),
    .rewind(rewind)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, compare with the model, step the model at the edge
  task automatic tick(input logic da, input logic g, input logic av,
                      input logic nk, input int num);
    int out, nb, nn, nt;
    logic retx, req, ok, exp_tmo, rew, sent;
    data_avail = da; tx_gnt = g; ack_valid = av; ack_neg = nk; ack_num = num[2:0];
    #2;
    out     = (mt - mb) & 7;
    retx    = (mn != mt);
    req     = retx || (da && out < 4);
    sent    = req && g;
    ok      = av && (((num - mb) & 7) < out);
    exp_tmo = (out > 0) && (mc == TMO - 1);
    rew     = (ok && nk) || (exp_tmo && !ok);
    chk("R5 tx_req", int'(tx_req), int'(req));
    chk("R1 tx_seq", int'(tx_seq), mn);
    chk("R6 tx_retx", int'(tx_retx), int'(retx));
    chk("R3 win_base", int'(win_base), mb);
    chk("R2 in_flight", int'(in_flight), out);
    chk("R2 win_full", int'(win_full), int'(out == 4));
    chk("R7 rewind", int'(rewind), int'(rew));
    seen_rew = rewind;
    nb = ok ? ((num + 1) & 7) : mb;
    nt = (sent && !retx) ? ((mt + 1) & 7) : mt;
    nn = sent ? ((mn + 1) & 7) : mn;
    if (rew) nn = nb;
    else if (ok && (((nn - mb) & 7) < ((nb - mb) & 7))) nn = nb;
    mc = (ok || rew || out == 0) ? 0 : mc + 1;
    @(posedge clk);
    mb = nb; mn = nn; mt = nt;
    @(negedge clk);
  endtask

  task automatic idle();
    tick(1'b0, 1'b0, 1'b0, 1'b0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    chk("R10 reset tx_req", int'(tx_req), 0);
    chk("R10 reset win_base", int'(win_base), 0);
    chk("R10 reset tx_seq", int'(tx_seq), 0);
    chk("R10 reset in_flight", int'(in_flight), 0);
    @(negedge clk);

    // fill the window with frames 0..3
    for (int i = 0; i < 4; i++) tick(1'b1, 1'b1, 1'b0, 1'b0, 0);
    chk("R2 four in flight", int'(in_flight), 4);
    chk("R2 full flag", int'(win_full), 1);
    tick(1'b1, 1'b1, 1'b0, 1'b0, 0);
    chk("R5 no fifth frame", int'(tx_seq), 4);

    // reports outside the range 0..3
    tick(1'b0, 1'b0, 1'b1, 1'b0, 5);
    tick(1'b0, 1'b0, 1'b1, 1'b0, 4);
    chk("R4 base kept", int'(win_base), 0);
    chk("R4 in_flight kept", int'(in_flight), 4);
    chk("R4 tx_seq kept", int'(tx_seq), 4);

    tick(1'b0, 1'b0, 1'b1, 1'b0, 1);
    chk("R3 base after ack 1", int'(win_base), 2);
    chk("R3 in_flight after ack 1", int'(in_flight), 2);

    tick(1'b0, 1'b0, 1'b1, 1'b1, 2);
    chk("R6 base after nak 2", int'(win_base), 3);
    chk("R6 tx_seq after nak 2", int'(tx_seq), 3);
    chk("R6 resend flagged", int'(tx_retx), 1);
    tick(1'b0, 1'b1, 1'b0, 1'b0, 0);
    chk("R5 resend without data", int'(tx_seq), 4);
    chk("R6 resend done", int'(tx_retx), 0);

    // timeout measured from a single fresh frame
    tick(1'b0, 1'b0, 1'b1, 1'b0, 3);
    chk("R8 empty after ack 3", int'(in_flight), 0);
    tick(1'b1, 1'b1, 1'b0, 1'b0, 0);
    begin
      int k;
      k = -1;
      for (int i = 0; i < 40; i++) begin
        idle();
        if (seen_rew) begin k = i; break; end
      end
      chk("R7 expiry cycle", k, TMO - 1);
    end
    chk("R7 tx_seq back to base", int'(tx_seq), 4);

    // base advance restarts the timer
    tick(1'b0, 1'b1, 1'b0, 1'b0, 0);
    tick(1'b1, 1'b1, 1'b0, 1'b0, 0);
    tick(1'b1, 1'b1, 1'b0, 1'b0, 0);
    for (int i = 0; i < 8; i++) idle();
    tick(1'b0, 1'b0, 1'b1, 1'b0, 4);
    begin
      int k;
      k = -1;
      for (int i = 0; i < 40; i++) begin
        idle();
        if (seen_rew) begin k = i; break; end
      end
      chk("R8 expiry after restart", k, TMO - 1);
    end
    chk("R8 tx_seq rewound to 5", int'(tx_seq), 5);

    // accepted positive report in the expiry cycle
    for (int i = 0; i < TMO - 1; i++) idle();
    tick(1'b0, 1'b0, 1'b1, 1'b0, 5);
    chk("R9 expiry dropped", int'(seen_rew), 0);
    chk("R11 tx_seq pulled to base", int'(tx_seq), 6);
    chk("R9 base after ack 5", int'(win_base), 6);

    // ignored report in the expiry cycle
    for (int i = 0; i < TMO - 1; i++) idle();
    tick(1'b0, 1'b0, 1'b1, 1'b0, 2);
    chk("R9 expiry kept", int'(seen_rew), 1);
    chk("R9 base unchanged", int'(win_base), 6);

    // wrap of the numbering
    tick(1'b0, 1'b0, 1'b1, 1'b0, 6);
    for (int i = 0; i < 4; i++) tick(1'b1, 1'b1, 1'b0, 1'b0, 0);
    chk("R1 wrapped tx_seq", int'(tx_seq), 3);
    chk("R1 wrapped in_flight", int'(in_flight), 4);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      logic da, g, av, nk;
      int num;
      da  = ($urandom_range(0, 9) < 7);
      g   = ($urandom_range(0, 9) < 6);
      av  = ($urandom_range(0, 19) < 3);
      nk  = ($urandom_range(0, 9) < 3);
      num = (mb + int'($urandom_range(0, 5))) & 7;
      tick(da, g, av, nk, num);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

endmodule